// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the execute-stage arithmetic unit of a small 32-bit RISC core. Each cycle it takes an operation code, two 32-bit operands and an execute-enable. The upstream operand mux has already chosen operand B: either a register value or a signed 12-bit immediate sign-extended to 32 bits. The unit computes a shift, a bitwise operation, a sum, a difference or a product. On the next clock edge it registers the 32-bit result together with a 4-bit condition register.

The condition register is never loaded from outside. It is exposed only as an output bus, which the core's condition-evaluation logic reads. Every accepted operation rewrites all four condition bits at once: a bit the operation does not set reads as zero afterwards. It never keeps its old value. Sign and zero are reported as three separate bits (negative, zero, positive), so exactly one of them is high after any accepted operation. Cycles where the instruction is suppressed leave both outputs untouched.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes 0 and `flags` becomes 4'b0000.
- R2: Code 0 shifts `opnd_a` left and code 1 shifts it right, both logically. The shift amount is the full unsigned value of `opnd_b`. An amount of 32 or more gives a result of 0.
- R3: For the shifts, the carry bit is the last bit shifted out. That is `opnd_a[32-n]` for a left shift and `opnd_a[n-1]` for a right shift, where n is in 1..32. The carry bit is 0 for n = 0 and for n > 32.
- R4: Codes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands. Code 5 gives the bitwise inverse of `opnd_a`, and `opnd_b` has no effect on it. All four clear the carry bit.
- R5: Code 6 gives `opnd_a + opnd_b` modulo 2^32. The carry bit is the carry out of bit 31.
- R6: Code 7 gives `opnd_a - opnd_b` in two's complement. The carry bit is the borrow, set exactly when `opnd_a < opnd_b` as unsigned numbers.
- R7: Code 8 gives the low 32 bits of the unsigned 64-bit product. The carry bit is set when the upper 32 bits of that product are not all zero.
- R8: The `flags` bit positions are [3] carry, [2] negative, [1] zero and [0] positive. After an accepted operation, the three sign bits describe the new `result` read as a signed 32-bit number, and exactly one of them is set.
- R9: `result` and `flags` change only at a clock edge where `exec_en` is high and the code is 0..8. The new values appear right after that edge. When `exec_en` is low, both hold regardless of the other inputs.
- R10: Codes 9 to 15 are reserved. With `exec_en` high they leave `result` and `flags` unchanged.
- R11: Each accepted operation rewrites all four flag bits. A bit left high by an earlier operation is cleared when the new operation does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute enable; low suppresses the operation |
| op_sel | input | 4 | Operation code (0..8 defined, 9..15 reserved) |
| opnd_a | input | 32 | First operand, shifted or inverted operand |
| opnd_b | input | 32 | Second operand or shift amount |
| result | output | 32 | Registered result |
| flags | output | 4 | Registered condition bits {C, N, Z, P} |

## Verification
The checker expects `exec_en` to be low while `rst` is high. It also treats codes 9 to 15 as legal input that must be ignored, so it does not exclude them from stimulus. The borrow and inversion properties compare against the operands of the previous cycle, which holds only because the outputs update exactly one edge after the operands are presented. The bench therefore drives operands once per cycle at the falling edge and never changes them mid-cycle. It always releases reset before it issues its first operation.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_SHL = 4'd0,
    OP_SHR = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_NOT = 4'd5,
    OP_ADD = 4'd6,
    OP_SUB = 4'd7,
    OP_MUL = 4'd8
  } alu_op_e;

  localparam int FLAG_W = 4;
  localparam int FB_C   = 3;
  localparam int FB_N   = 2;
  localparam int FB_Z   = 1;
  localparam int FB_P   = 0;

  localparam logic [3:0] LAST_OP = 4'd8;

endpackage

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 32
) (
  input  logic         left,
  input  logic [W-1:0] val,
  input  logic [W-1:0] amt,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int SAT   = W + 1;
  localparam int AMT_W = $clog2(W + 2);

  logic [AMT_W-1:0] amt_sat;
  logic [2*W:0]     ext_l;
  logic [2*W:0]     ext_r;

  // amounts above W+1 behave exactly like W+1: result and carry both zero
  always_comb begin
    if (amt > W'(SAT)) amt_sat = AMT_W'(SAT);
    else               amt_sat = amt[AMT_W-1:0];
  end

  always_comb begin
    ext_l = {{(W+1){1'b0}}, val} << amt_sat;
    ext_r = {val, {(W+1){1'b0}}} >> amt_sat;
    if (left) begin
      res  = ext_l[W-1:0];
      cout = ext_l[W];
    end else begin
      res  = ext_r[2*W:W+1];
      cout = ext_r[W];
    end
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = ~a;
    endcase
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W:0]     sum;
  logic [W:0]     diff;
  logic [2*W-1:0] prod;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b};
    diff = {1'b0, a} - {1'b0, b};
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    case (op)
      OP_ADD: begin
        res  = sum[W-1:0];
        cout = sum[W];
      end
      OP_SUB: begin
        res  = diff[W-1:0];
        cout = diff[W];
      end
      default: begin
        res  = prod[W-1:0];
        cout = |prod[2*W-1:W];
      end
    endcase
  end
endmodule

// File: rtl/alu_flaggen.sv
module alu_flaggen
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]        res,
  input  logic                carry,
  output logic [FLAG_W-1:0]   flg
);
  logic is_neg;
  logic is_zero;

  always_comb begin
    is_neg      = res[W-1];
    is_zero     = (res == '0);
    flg         = '0;
    flg[FB_C]   = carry;
    flg[FB_N]   = is_neg;
    flg[FB_Z]   = is_zero;
    flg[FB_P]   = !is_neg && !is_zero;
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         exec_en,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic [3:0]   flags
);
  logic [W-1:0]      sh_res, bw_res, ar_res, nxt_res;
  logic              sh_c, ar_c, nxt_c;
  logic [FLAG_W-1:0] nxt_flg;
  logic              accept;

  alu_shift #(.W(W)) u_shift (
    .left (op_sel == OP_SHL),
    .val  (opnd_a),
    .amt  (opnd_b),
    .res  (sh_res),
    .cout (sh_c)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .op  (op_sel),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (bw_res)
  );

  alu_arith #(.W(W)) u_arith (
    .op   (op_sel),
    .a    (opnd_a),
    .b    (opnd_b),
    .res  (ar_res),
    .cout (ar_c)
  );

  // result and carry source per operation class; logic ops carry nothing
  always_comb begin
    case (op_sel)
      OP_SHL, OP_SHR: begin
        nxt_res = sh_res;
        nxt_c   = sh_c;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        nxt_res = bw_res;
        nxt_c   = 1'b0;
      end
      default: begin
        nxt_res = ar_res;
        nxt_c   = ar_c;
      end
    endcase
  end

  alu_flaggen #(.W(W)) u_flaggen (
    .res   (nxt_res),
    .carry (nxt_c),
    .flg   (nxt_flg)
  );

  assign accept = exec_en && (op_sel <= LAST_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flags  <= '0;
    end else if (accept) begin
      result <= nxt_res;
      flags  <= nxt_flg;
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         exec_en,
  input logic [3:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic [3:0]   flags
);
  logic live;
  assign live = exec_en && (op_sel <= 4'd8);

  AST_SIGN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    live |=> $countones(flags[2:0]) == 1); // R8
  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (rst)
    live |=> flags[1] == (result == '0)); // R8
  AST_NEG_TRACK: assert property (@(posedge clk) disable iff (rst)
    live |=> flags[2] == result[W-1]); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(result) && $stable(flags)); // R9
  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel > 4'd8) |=> $stable(result) && $stable(flags)); // R10
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel >= 4'd2 && op_sel <= 4'd5) |=> !flags[3]); // R4
  AST_NOT_INVERT: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel == 4'd5) |=> result == ~$past(opnd_a)); // R4
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel == 4'd7) |=> flags[3] == ($past(opnd_a) < $past(opnd_b))); // R6
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .exec_en (exec_en),
  .op_sel  (op_sel),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .result  (result),
  .flags   (flags)
);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_en = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;
  logic [3:0]  flags;

  always #10 clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .flags(flags)
  );

  typedef struct {
    logic [31:0] r;
    logic [3:0]  f;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] m_res = '0;
  logic [3:0]  m_flg = '0;

  // reference model written from the requirements
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    longint unsigned wide;
    logic c;
    logic [31:0] r;
    c = 1'b0;
    r = '0;
    case (op)
      4'd0, 4'd1: begin
        if (b == 0) r = a;
        else if (b <= 32) begin
          if (op == 4'd0) begin
            r = (b == 32) ? 32'd0 : a << b;
            c = a[32 - b];
          end else begin
            r = (b == 32) ? 32'd0 : a >> b;
            c = a[b - 1];
          end
        end
      end
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a ^ b;
      4'd5: r = ~a;
      4'd6: begin wide = longint'(a) + longint'(b); r = wide[31:0]; c = wide[32]; end
      4'd7: begin r = a - b; c = (a < b); end
      default: begin wide = longint'(a) * longint'(b); r = wide[31:0]; c = (wide[63:32] != 0); end
    endcase
    m_res = r;
    m_flg = {c, $signed(r) < 0, r == 0, $signed(r) > 0};
  endtask

  task automatic issue(input logic en, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    exec_en = en;
    op_sel  = op;
    opnd_a  = a;
    opnd_b  = b;
    if (en && op <= 4'd8) model(op, a, b);
    e.r = m_res;
    e.f = m_flg;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: one expected item per cycle, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (result !== e.r || flags !== e.f) begin
          n_bad++;
          $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                   e.tag, result, flags, e.r, e.f);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    n_chk++;
    if (result !== 32'd0 || flags !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1: result=%h flags=%b expected 0 and 0000", result, flags);
    end
    @(negedge clk);
    rst = 1'b0;

    issue(1, 4'd0, 32'h0000_0001, 32'd4,  "R2 shl by 4");
    issue(1, 4'd0, 32'h8000_0001, 32'd1,  "R3 shl carry out");
    issue(1, 4'd0, 32'h0000_0001, 32'd32, "R3 shl by 32");
    issue(1, 4'd0, 32'hFFFF_FFFF, 32'd40, "R2 shl over 32");
    issue(1, 4'd1, 32'h8000_0000, 32'd31, "R2 shr by 31");
    issue(1, 4'd1, 32'h0000_0003, 32'd1,  "R3 shr carry out");
    issue(1, 4'd1, 32'h8000_0000, 32'd32, "R3 shr by 32");
    issue(1, 4'd1, 32'hF000_000F, 32'd0,  "R3 shr by 0");
    issue(1, 4'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, "R4 and");
    issue(1, 4'd3, 32'h0000_0000, 32'h0000_0000, "R4 or zero");
    issue(1, 4'd4, 32'hAAAA_5555, 32'hFFFF_0000, "R4 xor");
    issue(1, 4'd5, 32'h0000_00FF, 32'h1234_5678, "R4 not");
    issue(1, 4'd5, 32'h0000_00FF, 32'hFFFF_FFFF, "R4 not ignores b");
    issue(1, 4'd6, 32'hFFFF_FFFF, 32'h0000_0001, "R5 add wrap");
    issue(1, 4'd2, 32'hFFFF_FFFF, 32'h0000_0001, "R11 and clears carry");
    issue(1, 4'd6, 32'd5, 32'hFFFF_FFFD, "R5 add negative immediate");
    issue(1, 4'd6, 32'd100, 32'd23, "R5 add small");
    issue(1, 4'd7, 32'd3, 32'd5, "R6 sub borrow");
    issue(1, 4'd7, 32'd5, 32'd3, "R6 sub no borrow");
    issue(1, 4'd7, 32'd9, 32'd9, "R8 sub to zero");
    issue(1, 4'd8, 32'h0001_0000, 32'h0001_0000, "R7 mul overflow");
    issue(1, 4'd8, 32'd7, 32'd6, "R7 mul small");
    issue(1, 4'd8, 32'hFFFF_FFFF, 32'd1, "R8 mul negative");
    issue(0, 4'd6, 32'h1, 32'h1, "R9 suppressed add");
    issue(0, 4'd5, 32'h0, 32'h0, "R9 suppressed not");
    issue(1, 4'd12, 32'h0, 32'h0, "R10 reserved code");
    issue(1, 4'd15, 32'h5, 32'h5, "R10 reserved top code");
    issue(1, 4'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11 carry set again");
    issue(1, 4'd3, 32'h0, 32'h1, "R11 or clears carry");

    @(negedge clk);
    exec_en = 1'b0;
    wait (sb.size() == 0);
    @(posedge clk);
    #6;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule